// File: doc/BRIEF.md
# Signed ALU with Flag Register and Condition Evaluator

This block performs 32-bit signed integer arithmetic and logic for a simple sequential processor and keeps three flags (zero, sign, overflow) in a register. The operation is chosen by a 4-bit operation code, and the result is always formed as B op A, so subtraction yields B minus A. The result is combinational. The flags are written on a clock edge, and only when the write-flags input is high. The surrounding core raises that input only for arithmetic and logic instructions, so moves, jumps and stack operations leave the flags as they were.

A condition evaluator reads the stored flags and a 4-bit condition code and produces one "condition true" bit. The same bit serves conditional branches and conditional register moves. The block does not produce a carry, and it has no shift, OR or NOT operations. Any unsupported operation code or condition code raises an invalid-code output.

Top module: `cc_alu`

## Requirements
- R1: Operation code 0 adds, 1 subtracts (B minus A), 2 gives bitwise AND and 3 gives bitwise XOR. The result is combinational from the inputs.
- R2: When set_flags_i is high at a rising clock edge, the stored flags take the values of the result at that edge. Zero is set when the result is 0. Sign is result bit 31.
- R3: Overflow is set on add when A and B have the same sign and the result's sign differs from it. On subtract it is set when A and B differ in sign and the result's sign differs from B. It is 0 for AND and XOR. For example, 0x7fffffff + 0x7fffffff sets both overflow and sign.
- R4: While set_flags_i is low, the stored flags keep their values at every edge, whatever the operands and codes are.
- R5: After reset, zero is 1, sign is 0 and overflow is 0.
- R6: Condition codes select the following tests on the stored flags: 0 always true, 1 sign|zero, 2 sign&!zero, 3 zero, 4 !zero, 5 !sign|zero, 6 !sign&!zero. Overflow is not used in any of these tests.
- R7: bad_op_o is high whenever the operation code is 4 to 15. bad_cond_o is high whenever the condition code is 7 to 15, and cond_o is 0 in that case. A write-flags edge with a bad operation code stores flags from a zero result: zero 1, sign 0, overflow 0.
- R8: flags_o presents the stored flags as {overflow, sign, zero}, with zero in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Write the flags at the next edge |
| cond_i | input | 4 | Condition code |
| result_o | output | 32 | B op A |
| flags_o | output | 3 | Stored flags {ovf, sign, zero} |
| cond_o | output | 1 | Condition true |
| bad_op_o | output | 1 | Unsupported operation code |
| bad_cond_o | output | 1 | Unsupported condition code |

## Verification
A new operation and a condition test can occur in the same cycle. While a flag write is pending, cond_o must still reflect the old flags, and it switches to the new flags only after the edge. The bench provokes this by driving a flag-setting operation and a condition code together. It then samples cond_o before the edge and compares it with a value predicted from the old flags. After the edge it compares cond_o with a value predicted from the new flags, sweeping all condition codes. It also sweeps the corner cases of signed overflow in both directions.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_XOR = 4'd3
  } alu_op_e;
  typedef enum logic [3:0] {
    C_ALW = 4'd0, C_LE = 4'd1, C_LT = 4'd2, C_EQ = 4'd3,
    C_NE  = 4'd4, C_GE = 4'd5, C_GT = 4'd6
  } cond_e;
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
  } flags_t;
endpackage

// File: rtl/cc_alu_core.sv
module cc_alu_core
  import cc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output flags_t       nflags_o,
  output logic         bad_o
);
  localparam int MSB = W - 1;
  logic [W-1:0] sum, dif;
  logic ovf_add, ovf_sub;

  assign sum = b_i + a_i;
  assign dif = b_i - a_i;
  assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != b_i[MSB]);
  assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != b_i[MSB]);

  always_comb begin
    res_o = '0;
    nflags_o.ovf = 1'b0;
    bad_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin res_o = sum; nflags_o.ovf = ovf_add; end
      OP_SUB: begin res_o = dif; nflags_o.ovf = ovf_sub; end
      OP_AND: res_o = b_i & a_i;
      OP_XOR: res_o = b_i ^ a_i;
      default: bad_o = 1'b1;
    endcase
    nflags_o.sgn = res_o[MSB];
    nflags_o.zro = (res_o == '0);
  end

  always_comb begin
    assert_logic_ovf_R3: assert (!((op_i == OP_AND || op_i == OP_XOR) && nflags_o.ovf));
  end
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_alu_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] cond_i,
  output logic       take_o,
  output logic       bad_o
);
  always_comb begin
    take_o = 1'b0;
    bad_o  = 1'b0;
    unique case (cond_i)
      C_ALW: take_o = 1'b1;
      C_LE:  take_o = flags_i.sgn | flags_i.zro;
      C_LT:  take_o = flags_i.sgn & ~flags_i.zro;
      C_EQ:  take_o = flags_i.zro;
      C_NE:  take_o = ~flags_i.zro;
      C_GE:  take_o = ~flags_i.sgn | flags_i.zro;
      C_GT:  take_o = ~flags_i.sgn & ~flags_i.zro;
      default: bad_o = 1'b1;
    endcase
  end

  always_comb begin
    assert_bad_quiet_R7: assert (!(bad_o && take_o));
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         set_flags_i,
  input  logic [3:0]   cond_i,
  output logic [W-1:0] result_o,
  output logic [2:0]   flags_o,
  output logic         cond_o,
  output logic         bad_op_o,
  output logic         bad_cond_o
);
  localparam flags_t FLAGS_RST = '{ovf: 1'b0, sgn: 1'b0, zro: 1'b1};
  flags_t nflags, flags_q;

  cc_alu_core #(.W(W)) u_core (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .res_o(result_o), .nflags_o(nflags), .bad_o(bad_op_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flags_q <= FLAGS_RST;
    else if (set_flags_i) flags_q <= nflags;
  end

  cc_cond_eval u_cond (
    .flags_i(flags_q), .cond_i(cond_i),
    .take_o(cond_o), .bad_o(bad_cond_o)
  );

  assign flags_o = flags_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_flags_i |=> $stable(flags_o));
  assert_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && result_o == '0) |=> flags_o[0]);
  assert_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> (flags_o[1] == $past(result_o[W-1])));
  assert_eq_cond_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd3) |-> (cond_o == flags_o[0]));
  assert_always_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd0) |-> cond_o);
endmodule

// File: tb/cc_alu_tb.sv
module cc_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0] op, cnd;
  logic sf, co, bop, bco;
  logic [2:0] fl;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op),
    .set_flags_i(sf), .cond_i(cnd), .result_o(res), .flags_o(fl),
    .cond_o(co), .bad_op_o(bop), .bad_cond_o(bco)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_res(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      4'd0: return y + x;
      4'd1: return y - x;
      4'd2: return y & x;
      4'd3: return y ^ x;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [2:0] m_flags(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, r;
    logic v;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    v = 1'b0;
    if (o == 4'd0) begin r = sy + sx; v = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
    if (o == 4'd1) begin r = sy - sx; v = (r > 64'sd2147483647) || (r < -64'sd2147483648); end
    return {v, m_res(o, x, y)[31], m_res(o, x, y) == 32'd0};
  endfunction

  function automatic logic m_cond(input logic [3:0] c, input logic [2:0] f);
    logic s, z;
    s = f[1]; z = f[0];
    case (c)
      4'd0: return 1'b1;
      4'd1: return s || z;
      4'd2: return s && !z;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !s || z;
      4'd6: return !s && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_cond(input string req, input logic [2:0] f);
    for (int c = 0; c < 16; c++) begin
      cnd = 4'(c);
      #1;
      chk(req, {31'd0, co}, {31'd0, m_cond(4'(c), f)});
      chk("R7", {31'd0, bco}, {31'd0, c > 6});
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [2:0] oldf;
    @(negedge clk);
    oldf = fl;
    op = o; a = x; b = y; sf = 1'b1; cnd = 4'd1;
    #1;
    chk("R1", res, m_res(o, x, y));
    chk("R7", {31'd0, bop}, {31'd0, o > 3});
    chk("R6", {31'd0, co}, {31'd0, m_cond(4'd1, oldf)});
    @(negedge clk);
    sf = 1'b0;
    chk(o == 0 || o == 1 ? "R3" : "R2", {29'd0, fl}, {29'd0, m_flags(o, x, y)});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [8];
    logic [2:0] keep;
    pats = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h80000001, 32'h12345678, 32'hedcba988};
    a = '0; b = '0; op = '0; sf = 1'b0; cnd = '0;
    #(CLK_PERIOD * 2 + 3);
    chk("R5", {29'd0, fl}, 32'd1);
    chk("R8", {31'd0, fl[0]}, 32'd1);
    sweep_cond("R6", 3'b001);
    rst_n = 1'b1;
    do_op(4'd0, 32'h7fffffff, 32'h7fffffff);
    chk("R3", {29'd0, fl}, 32'd6);
    sweep_cond("R6", fl);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          do_op(4'(o), pats[i], pats[j]);
          if (o < 4 && j == i) sweep_cond("R6", fl);
        end
    // R7 bad op after non-zero flags
    do_op(4'd1, 32'h1, 32'h0);
    do_op(4'd9, 32'h5, 32'h7);
    chk("R7", {29'd0, fl}, 32'd1);
    // R4 hold with flags off
    do_op(4'd1, 32'h2, 32'h1);
    keep = fl;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      op = 4'(k); a = pats[k % 8]; b = pats[(k + 3) % 8]; sf = 1'b0;
      @(negedge clk);
      chk("R4", {29'd0, fl}, {29'd0, keep});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule